// File: doc/BRIEF.md
# Stamped Ring Entry Producer

This block is the producer side of a circular descriptor ring in on-chip memory. It accepts one fixed-size entry per cycle through a valid/ready handshake. Each entry is eight 32-bit words, and the block writes the whole entry into the slot under its head pointer. Before storing, it overwrites the top twelve bits of the entry's last word with a fixed ring identifier and a wrapping pass counter.

The consumer reads entries back through a synchronous word-addressed read port. It returns slots by loading its tail pointer into the block. It can tell freshly written entries from stale ones by looking at the low bit of the pass counter, so it never needs the producer's head pointer.

The block reports its occupancy and a full flag. It withholds ready while one free slot remains, so the head never catches up with the tail.

Top module: `ring_stamp_producer`

## Requirements
- R1: After reset the head pointer, the tail pointer, the loop count and the occupancy are all 0, and `in_ready` is 1.
- R2: An accepted entry is stored in the slot the head pointed to. Word w of the entry is input bits [32w+31:32w]. Words 0 to 6 are stored unchanged. A word selected on the read port appears on `rd_data` one clock later.
- R3: In the stored word 7, bits [27:20] hold the `RING_ID` parameter and bits [19:0] equal the input. The input's bits [31:20] of word 7 are ignored.
- R4: Bits [31:28] of stored word 7 hold (loop count + 1) mod 16, taken at the moment of writing. Entries written on the first pass therefore carry 1, and entries written while the loop count is 15 carry 0.
- R5: Each accepted entry advances the head by one, and the head wraps from DEPTH-1 to 0. `loop_count` increments on each such wrap and rolls over from 15 to 0. Neither changes at any other time.
- R6: The ring is full when head+1 (mod DEPTH) equals the tail. While full, `in_ready` is 0 and a valid entry is not accepted: the head, the loop count and the occupancy do not change.
- R7: A tail update loads `tail_ptr` on the next clock edge. `occupancy` is always (head - tail) mod DEPTH.
- R8: Slots rewritten on the current pass differ in stamp LSB from slots still holding the previous pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Ring can accept an entry |
| in_entry | input | WORDS*32 | Entry; word w at bits [32w+31:32w] |
| tail_we | input | 1 | Load consumer tail pointer |
| tail_ptr | input | log2(DEPTH) | New tail slot index |
| rd_slot | input | log2(DEPTH) | Slot to read |
| rd_word | input | log2(WORDS) | Word within slot to read |
| rd_data | output | 32 | Read word, one cycle after address |
| head_ptr | output | log2(DEPTH) | Next slot to be written |
| occupancy | output | log2(DEPTH) | Entries held |
| full | output | 1 | No free slot may be written |
| loop_count | output | 4 | Completed wraps of the head, modulo 16 |

## Verification
The head pointer, loop count, occupancy and full flag all change on the clock edge that accepts an entry or loads the tail. The bench drives each stimulus on a falling edge and samples these results on the next falling edge. A read is one cycle deeper: the bench presents the address on a falling edge and compares `rd_data` one full cycle later, after the registered read. The bench keeps its own model of the head, the tail and the loop count, and it uses that model to decide both whether a push should be accepted and which stamp each slot must carry.

// File: rtl/ring_stamp_producer.sv
module ring_stamp_producer #(
  parameter int DEPTH = 8,
  parameter int WORDS = 8,
  parameter logic [7:0] RING_ID = 8'h5C,
  localparam int AW = $clog2(DEPTH),
  localparam int WSEL = $clog2(WORDS),
  localparam int EW = WORDS * 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [EW-1:0]   in_entry,
  input  logic            tail_we,
  input  logic [AW-1:0]   tail_ptr,
  input  logic [AW-1:0]   rd_slot,
  input  logic [WSEL-1:0] rd_word,
  output logic [31:0]     rd_data,
  output logic [AW-1:0]   head_ptr,
  output logic [AW-1:0]   occupancy,
  output logic            full,
  output logic [3:0]      loop_count
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q, tail_q, head_nx;
  logic [3:0]    lap_q;
  logic [EW-1:0] stamped;
  logic          push, at_last;

  assign head_nx   = head_q + AW'(1);
  assign full      = (head_nx == tail_q);
  assign in_ready  = !full;
  assign push      = in_valid && in_ready;
  assign at_last   = (head_q == AW'(DEPTH - 1));
  assign head_ptr  = head_q;
  assign occupancy = head_q - tail_q;
  assign loop_count = lap_q;

  always_comb begin
    stamped = in_entry;
    stamped[EW-1 -: 12] = {lap_q + 4'd1, RING_ID};
  end

  always_ff @(posedge clk) begin
    if (push) mem[head_q] <= stamped;
    rd_data <= mem[rd_slot][{rd_word, 5'b0} +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      lap_q  <= '0;
    end else begin
      if (push) head_q <= head_nx;
      if (push && at_last) lap_q <= lap_q + 4'd1;
      if (tail_we) tail_q <= tail_ptr;
    end
  end

endmodule

// File: rtl/ring_stamp_producer_chk.sv
module ring_stamp_producer_chk #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          tail_we,
  input logic [AW-1:0] tail_ptr,
  input logic [AW-1:0] head_ptr,
  input logic [AW-1:0] occupancy,
  input logic          full,
  input logic [3:0]    loop_count
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> head_ptr == '0 && loop_count == 4'd0 && occupancy == '0); // R1
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> head_ptr == $past(head_ptr) + AW'(1)); // R5
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(head_ptr)); // R5
  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && head_ptr == AW'(DEPTH - 1)) |=> loop_count == $past(loop_count) + 4'd1); // R5
  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && in_ready && head_ptr == AW'(DEPTH - 1)) |=> $stable(loop_count)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && in_valid && !tail_we) |=> $stable(head_ptr) && $stable(occupancy)); // R6
  AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tail_we |=> occupancy == head_ptr - $past(tail_ptr)); // R7

endmodule

bind ring_stamp_producer ring_stamp_producer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .tail_we(tail_we), .tail_ptr(tail_ptr), .head_ptr(head_ptr),
  .occupancy(occupancy), .full(full), .loop_count(loop_count)
);

// File: tb/sim_ring_stamp_producer.sv
`timescale 1ns/1ps
module sim_ring_stamp_producer;
  localparam int D = 8;
  localparam int W = 8;
  localparam logic [7:0] RID = 8'h3A;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, tail_we = 0;
  logic [W*32-1:0] in_entry = '0;
  logic [2:0] tail_ptr = '0, rd_slot = '0, head_ptr, occupancy;
  logic [2:0] rd_word = '0;
  logic [31:0] rd_data;
  logic in_ready, full;
  logic [3:0] loop_count;

  int checks = 0, errors = 0;
  int head_m = 0, tail_m = 0, lc_m = 0;

  always #2.5 clk = ~clk;

  ring_stamp_producer #(.DEPTH(D), .WORDS(W), .RING_ID(RID)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_entry(in_entry), .tail_we(tail_we), .tail_ptr(tail_ptr),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data),
    .head_ptr(head_ptr), .occupancy(occupancy), .full(full),
    .loop_count(loop_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W*32-1:0] mk(input logic [7:0] tag);
    logic [W*32-1:0] e;
    for (int w = 0; w < W; w++) e[w*32 +: 32] = {tag | 8'hF0, 8'(w), 4'hB, tag, 4'h7};
    return e;
  endfunction

  task automatic push(input logic [7:0] tag);
    bit acc;
    @(negedge clk);
    acc = ((head_m + 1) % D) != tail_m;
    chk("R6 ready", 32'(in_ready), 32'(acc));
    in_valid = 1; in_entry = mk(tag);
    @(negedge clk);
    in_valid = 0;
    if (acc) begin
      if (head_m == D - 1) lc_m = (lc_m + 1) % 16;
      head_m = (head_m + 1) % D;
    end
    chk("R5 head", 32'(head_ptr), 32'(head_m));
    chk("R5 loop", 32'(loop_count), 32'(lc_m));
  endtask

  task automatic set_tail(input int t);
    @(negedge clk);
    tail_we = 1; tail_ptr = 3'(t);
    @(negedge clk);
    tail_we = 0; tail_m = t;
    chk("R7 occupancy", 32'(occupancy), 32'((head_m - tail_m + D) % D));
  endtask

  task automatic rd(input int slot, input int w, output logic [31:0] d);
    @(negedge clk);
    rd_slot = 3'(slot); rd_word = 3'(w);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 head", 32'(head_ptr), 0);
    chk("R1 loop", 32'(loop_count), 0);
    chk("R1 occupancy", 32'(occupancy), 0);
    chk("R1 ready", 32'(in_ready), 1);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    logic [W*32-1:0] e;
    for (int i = 1; i < D; i++) push(8'(i));
    chk("R6 full", 32'(full), 1);
    chk("R7 occupancy full", 32'(occupancy), D - 1);
    push(8'h77);
    chk("R6 occupancy hold", 32'(occupancy), D - 1);
    e = mk(8'd4);
    rd(3, 0, d); chk("R2 word0", d, e[31:0]);
    rd(3, 5, d); chk("R2 word5", d, e[5*32 +: 32]);
    rd(3, 7, d);
    chk("R3 word7 stamp", d, {4'd1, RID, e[W*32-13 -: 20]});
    chk("R4 first pass", 32'(d[31:28]), 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d0, d1, d7;
    set_tail(D - 1);
    chk("R6 not full", 32'(full), 0);
    push(8'h21);
    push(8'h22);
    rd(D - 1, 7, d7); chk("R4 last slot pass1", 32'(d7[31:28]), 1);
    rd(0, 7, d0); chk("R4 slot0 pass2", 32'(d0[31:28]), 2);
    chk("R3 id", 32'(d0[27:20]), 32'(RID));
    rd(1, 7, d1);
    chk("R8 fresh vs stale lsb", 32'(d0[28] ^ d1[28]), 1);
    set_tail(1);
  endtask

  task automatic t_rollover();
    logic [31:0] d;
    int guard = 0;
    bit done = 0;
    while (!done && guard < 200) begin
      bit was15 = (lc_m == 15);
      set_tail(head_m);
      push(8'(guard));
      if (was15 && lc_m == 0) done = 1;
      guard++;
    end
    chk("R5 rollover to 0", 32'(loop_count), 0);
    rd(3, 7, d);
    chk("R4 stamp after 15", 32'(d[31:28]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_wrap();
    t_rollover();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule